// File: doc/BRIEF.md
# Majority-Voted Delay-Race Response Controller

This block sits between a requester and a bank of eight delay-race response generators. It takes a 64-bit challenge over a valid/ready handshake. It overwrites the top twelve challenge bits with a fixed pattern that offsets the built-in bias of the generators' end-of-race latches, and then presents the result to all eight generators at once. It then starts the race repeatedly. For each start it raises a launch line, holds it for the settle time of the delay chains, and samples the eight generator outputs in the final cycle of that window. After that it drops the launch line so the generators can re-arm.

Each generator output is evaluated eleven times. Every response bit is decided by a majority over its eleven samples, which filters out the occasional noisy race. The 8-bit response is then held with a valid flag until the requester consumes it. The next challenge is accepted only after that. The generators themselves and any later key processing are outside this block.

Top module: `puf_meas_ctrl`

## Requirements
- R1: After reset, `chal_ready` is 1, `resp_valid` is 0 and `gen_launch` is 0.
- R2: On a challenge accept (`chal_valid` and `chal_ready` both high at a clock edge), `gen_challenge[51:0]` takes `chal_data[51:0]` and `gen_challenge[63:52]` takes the fixed pattern 12'hA5C (parameter default).
- R3: `gen_challenge` stays unchanged from the accept until the response is consumed, whatever `chal_data` does meanwhile.
- R4: Each accepted challenge produces exactly 11 launch pulses.
- R5: Every launch pulse keeps `gen_launch` high for exactly 5 consecutive cycles.
- R6: Between two launch pulses of the same challenge, `gen_launch` is low for exactly one cycle.
- R7: Only the value of `gen_sample` during the last high cycle of each launch pulse is counted. Values presented while `gen_launch` is low have no effect on the response.
- R8: Response bit i is 1 exactly when `gen_sample[i]` was 1 in 6 or more of the 11 counted samples. A count of 5 gives 0 and a count of 6 gives 1.
- R9: While `resp_valid` is high and `resp_ready` is low, `resp_valid` stays high, `resp_data` stays stable, `chal_ready` stays low and no new challenge is accepted.
- R10: After a response is consumed (`resp_valid` and `resp_ready` high at an edge), `resp_valid` is 0 and `chal_ready` is 1 from the next cycle. The next challenge's tallies start from zero.
- R11: `resp_valid` rises 65 clock edges after the accept edge: 11 windows of 5 cycles plus 10 re-arm cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chal_valid | input | 1 | Challenge offered |
| chal_ready | output | 1 | Controller idle and able to take a challenge |
| chal_data | input | 64 | Challenge from requester |
| gen_challenge | output | 64 | Skew-compensated challenge to all generators |
| gen_launch | output | 1 | Race start; high for the settle window |
| gen_sample | input | 8 | One race result bit per generator |
| resp_valid | output | 1 | Voted response available |
| resp_ready | input | 1 | Requester takes the response |
| resp_data | output | 8 | Majority-voted response |

## Verification
The hardest cases to reach are the two vote boundaries, exactly five ones against exactly six, and proof that samples outside the sampling cycle are ignored. The bench models the generators as a reactive process. That process watches `gen_launch`, numbers each pulse, and drives a per-pulse pattern built so that different bits receive chosen counts such as 0, 5, 6 and 11. Whenever the launch line is low it drives the bitwise inverse of that pattern, so any sampling outside the window would shift a boundary bit. A run with back-pressure holds a finished response while junk challenges are offered, and this covers the hold and no-accept behaviour.

// File: rtl/puf_meas_pkg.sv
// Shared types for the response measurement controller.
// Assumes nothing beyond a synthesizable enum encoding.
package puf_meas_pkg;

    // Controller phases, in sequence order.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LAUNCH = 3'd1,
        PH_REARM  = 3'd2,
        PH_HOLD   = 3'd3
    } meas_phase_e;

endpackage

// File: rtl/puf_chal_mask.sv
// Challenge register with skew compensation.
// Captures the requester's challenge on load and replaces every bit at or
// above FIX_LO with the low bits of FIX_VAL. Holds its value between loads.
// Assumes FIX_LO < CHAL_W and CHAL_W <= 64.
module puf_chal_mask #(
    parameter int unsigned CHAL_W  = 64,
    parameter int unsigned FIX_LO  = 52,
    parameter logic [63:0] FIX_VAL = 64'hA5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAL_W-1:0] chal_in,
    output logic [CHAL_W-1:0] chal_out
);
    localparam int unsigned FIX_W = CHAL_W - FIX_LO;

    logic [CHAL_W-1:0] masked;
    logic [CHAL_W-1:0] chal_q;

    // Build the masked challenge: user bits below FIX_LO, constants above.
    generate
        genvar b;
        for (b = 0; b < CHAL_W; b++) begin : g_bit
            if (b < FIX_LO) begin : g_user
                assign masked[b] = chal_in[b];
            end else begin : g_fixed
                assign masked[b] = FIX_VAL[b - FIX_LO];
            end
        end
    endgenerate

    // Hold register, reloaded only on an accepted challenge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chal_q <= '0;
        else if (load)
            chal_q <= masked;
    end

    assign chal_out = chal_q;

    // R2: after a load the fixed field carries the compensation pattern.
    a_r2_fixed_field: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (chal_out[CHAL_W-1:FIX_LO] == FIX_VAL[FIX_W-1:0]));

    // R3: without a load the presented challenge does not move.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(chal_out));

endmodule

// File: rtl/puf_eval_seq.sv
// Evaluation sequencer.
// Starts NUM_EVAL races per challenge. Each race keeps launch high for
// SETTLE_CYC cycles and requests a sample in the last of them. Launch then
// drops for one re-arm cycle. After the last sample the sequencer holds the
// result phase until consume.
// Assumes SETTLE_CYC >= 2 and NUM_EVAL >= 1.
module puf_eval_seq
    import puf_meas_pkg::*;
#(
    parameter int unsigned NUM_EVAL   = 11,
    parameter int unsigned SETTLE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic consume,
    output logic idle,
    output logic launch,
    output logic sample_en,
    output logic done
);
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
    localparam int unsigned EW = $clog2(NUM_EVAL + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [EW-1:0] EVAL_LAST   = EW'(NUM_EVAL - 1);

    meas_phase_e    phase_q;
    logic [SW-1:0]  settle_q;
    logic [EW-1:0]  eval_q;
    logic           window_end;

    assign window_end = (phase_q == PH_LAUNCH) && (settle_q == SETTLE_LAST);

    // Phase, settle-window and evaluation counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            settle_q <= '0;
            eval_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_LAUNCH;
                        settle_q <= '0;
                        eval_q   <= '0;
                    end
                end
                PH_LAUNCH: begin
                    if (window_end) begin
                        settle_q <= '0;
                        if (eval_q == EVAL_LAST) begin
                            phase_q <= PH_HOLD;
                        end else begin
                            eval_q  <= eval_q + 1'b1;
                            phase_q <= PH_REARM;
                        end
                    end else begin
                        settle_q <= settle_q + 1'b1;
                    end
                end
                PH_REARM: phase_q <= PH_LAUNCH;
                PH_HOLD: begin
                    if (consume)
                        phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Decode phase into control strobes.
    always_comb begin
        idle      = (phase_q == PH_IDLE);
        launch    = (phase_q == PH_LAUNCH);
        sample_en = window_end;
        done      = (phase_q == PH_HOLD);
    end

    // R5: a launch cycle that is not the first of its window follows a launch cycle.
    a_r5_window_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && settle_q != '0) |-> $past(launch));

    // R6: a window that ends before the last evaluation is followed by exactly one low cycle.
    a_r6_one_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && eval_q != EVAL_LAST) |=> (!launch ##1 launch));

    // R4: the evaluation index never passes the last evaluation.
    a_r4_eval_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eval_q <= EVAL_LAST);

endmodule

// File: rtl/puf_vote_tally.sv
// Per-generator vote counters.
// One counter per generator counts ones over the sampled races. It is
// cleared when a challenge is accepted. A bit votes 1 when its count
// reaches a strict majority of NUM_EVAL. Assumes NUM_EVAL is odd.
module puf_vote_tally #(
    parameter int unsigned NUM_GEN  = 8,
    parameter int unsigned NUM_EVAL = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample_en,
    input  logic [NUM_GEN-1:0] bits_in,
    output logic [NUM_GEN-1:0] vote
);
    localparam int unsigned CW = $clog2(NUM_EVAL + 1);
    localparam logic [CW-1:0] THRESH = CW'(NUM_EVAL / 2 + 1);
    localparam logic [CW-1:0] CAP    = CW'(NUM_EVAL);

    generate
        genvar g;
        for (g = 0; g < NUM_GEN; g++) begin : g_ctr
            logic [CW-1:0] cnt_q;

            // Count ones seen on this generator for the current challenge.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    cnt_q <= '0;
                else if (sample_en && bits_in[g])
                    cnt_q <= cnt_q + 1'b1;
            end

            assign vote[g] = (cnt_q >= THRESH);

            // R8: a tally can never exceed the number of evaluations.
            a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CAP);
        end
    endgenerate

endmodule

// File: rtl/puf_meas_ctrl.sv
// Top of the response measurement controller.
// Accepts a challenge, masks its high bits, starts repeated races on the
// generator bank and publishes a majority-voted response, held until consumed.
// Assumes the generators keep gen_sample steady from early in each launch
// window until launch falls.
module puf_meas_ctrl #(
    parameter int unsigned CHAL_W     = 64,
    parameter int unsigned FIX_LO     = 52,
    parameter logic [63:0] FIX_VAL    = 64'hA5C,
    parameter int unsigned NUM_GEN    = 8,
    parameter int unsigned NUM_EVAL   = 11,
    parameter int unsigned SETTLE_CYC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chal_valid,
    output logic               chal_ready,
    input  logic [CHAL_W-1:0]  chal_data,
    output logic [CHAL_W-1:0]  gen_challenge,
    output logic               gen_launch,
    input  logic [NUM_GEN-1:0] gen_sample,
    output logic               resp_valid,
    input  logic               resp_ready,
    output logic [NUM_GEN-1:0] resp_data
);
    logic accept;
    logic consume;
    logic sample_en;
    logic seq_idle;
    logic seq_done;
    logic [NUM_GEN-1:0] vote;

    // Handshake events.
    assign accept  = chal_valid && seq_idle;
    assign consume = seq_done && resp_ready;

    puf_chal_mask #(
        .CHAL_W (CHAL_W),
        .FIX_LO (FIX_LO),
        .FIX_VAL(FIX_VAL)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .chal_in (chal_data),
        .chal_out(gen_challenge)
    );

    puf_eval_seq #(
        .NUM_EVAL  (NUM_EVAL),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .consume  (consume),
        .idle     (seq_idle),
        .launch   (gen_launch),
        .sample_en(sample_en),
        .done     (seq_done)
    );

    puf_vote_tally #(
        .NUM_GEN (NUM_GEN),
        .NUM_EVAL(NUM_EVAL)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample_en(sample_en),
        .bits_in  (gen_sample),
        .vote     (vote)
    );

    // Drive the requester-facing outputs.
    assign chal_ready = seq_idle;
    assign resp_valid = seq_done;
    assign resp_data  = vote;

    // R9: a response waiting for its consumer stays valid and unchanged.
    a_r9_hold_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

    // R1: the controller never offers ready while a response is pending.
    a_r1_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(chal_ready && resp_valid));

    // R10: consumption returns the controller to idle on the next cycle.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready) |=> (chal_ready && !resp_valid));

    // R3: no launch is ever seen while idle.
    a_r3_no_idle_launch: assert property (@(posedge clk) disable iff (!rst_n)
        chal_ready |-> !gen_launch);

endmodule

// File: tb/tb_puf_meas_ctrl.sv
// Directed bench: a reactive generator model plus one task per scenario.
module tb_puf_meas_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chal_valid = 1'b0;
    logic        chal_ready;
    logic [63:0] chal_data = '0;
    logic [63:0] gen_challenge;
    logic        gen_launch;
    logic [7:0]  gen_sample = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [7:0]  resp_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Generator model state.
    logic [7:0]  pat [0:10];
    logic [7:0]  cur_pat = '0;
    logic [63:0] exp_chal = '0;
    bit          tracking = 0;
    bit          prev_l = 0;
    int          pulse_cnt = 0;
    int          hi_len = 0;
    int          low_len = 0;

    always #4 clk = ~clk;

    puf_meas_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .chal_valid(chal_valid), .chal_ready(chal_ready), .chal_data(chal_data),
        .gen_challenge(gen_challenge), .gen_launch(gen_launch), .gen_sample(gen_sample),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reactive generator model and launch-shape monitor, at the falling edge.
    always @(negedge clk) begin
        if (rst_n && tracking) begin
            if (gen_launch) begin
                if (!prev_l) begin
                    if (pulse_cnt > 0)
                        chk(low_len == 1, "R6 re-arm gap", 64'(low_len), 64'd1);
                    pulse_cnt++;
                    hi_len = 1;
                    cur_pat = (pulse_cnt <= 11) ? pat[pulse_cnt-1] : 8'h00;
                    chk(gen_challenge == exp_chal, "R3 challenge stable", gen_challenge, exp_chal);
                end else begin
                    hi_len++;
                end
                gen_sample = cur_pat;
            end else begin
                if (prev_l)
                    chk(hi_len == 5, "R5 launch width", 64'(hi_len), 64'd5);
                low_len = prev_l ? 1 : low_len + 1;
                gen_sample = ~cur_pat;   // R7: junk outside the window
            end
            prev_l = gen_launch;
        end
    end

    // One full challenge: offer, measure latency, check vote, optional back-pressure, consume.
    task automatic run_chal(input logic [63:0] d, input int hold);
        int k;
        logic [7:0] exp_resp;
        logic [7:0] first_resp;
        for (int i = 0; i < 8; i++) begin
            int ones = 0;
            for (int e = 0; e < 11; e++) ones += pat[e][i];
            exp_resp[i] = (ones >= 6);
        end
        @(negedge clk);
        chk(chal_ready == 1'b1, "R10 ready before offer", 64'(chal_ready), 64'd1);
        exp_chal = {12'hA5C, d[51:0]};
        pulse_cnt = 0;
        prev_l = 0;
        tracking = 1;
        chal_data = d;
        chal_valid = 1'b1;
        @(posedge clk);
        k = 0;
        @(negedge clk);
        chk(gen_challenge == exp_chal, "R2 masked challenge", gen_challenge, exp_chal);
        chal_valid = 1'b1;            // R9: junk offers while busy
        chal_data = ~d;
        while (!resp_valid && k < 200) begin
            chk(chal_ready == 1'b0, "R9 no ready while busy", 64'(chal_ready), 64'd0);
            @(posedge clk);
            k++;
            @(negedge clk);
        end
        chk(k == 65, "R11 latency", 64'(k), 64'd65);
        chk(pulse_cnt == 11, "R4 pulse count", 64'(pulse_cnt), 64'd11);
        chk(resp_data == exp_resp, "R8 majority vote", resp_data, exp_resp);
        first_resp = resp_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(resp_valid && !chal_ready && resp_data == first_resp, "R9 hold response",
                {resp_valid, chal_ready, resp_data}, {2'b10, first_resp});
            chk(gen_challenge == exp_chal, "R9 no new accept", gen_challenge, exp_chal);
        end
        chal_valid = 1'b0;
        resp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resp_ready = 1'b0;
        chk(!resp_valid && chal_ready, "R10 release", {resp_valid, chal_ready}, 2'b01);
        tracking = 0;
        gen_sample = '0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(chal_ready && !resp_valid && !gen_launch, "R1 reset outputs",
            {chal_ready, resp_valid, gen_launch}, 3'b100);
        rst_n = 1'b1;
    endtask

    // R8/R7: counts 0,5,6,11,3,8,1,10 per bit; boundary 5 vs 6.
    task automatic t_boundary();
        int c [8] = '{0, 5, 6, 11, 3, 8, 1, 10};
        for (int e = 0; e < 11; e++)
            for (int i = 0; i < 8; i++) pat[e][i] = (e < c[i]);
        run_chal(64'hFFFF_FFFF_FFFF_FFFF, 0);
    endtask

    // R8: scattered sample patterns, back-pressure for R9.
    task automatic t_scatter();
        logic [7:0] s = 8'h5B;
        for (int e = 0; e < 11; e++) begin
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
            pat[e] = s ^ 8'(e * 37);
        end
        run_chal(64'h0123_4567_89AB_CDEF, 20);
    endtask

    // R10: all ones then all zeros, no carry-over between challenges.
    task automatic t_fresh();
        for (int e = 0; e < 11; e++) pat[e] = 8'hFF;
        run_chal(64'h0000_0000_0000_0000, 2);
        for (int e = 0; e < 11; e++) pat[e] = 8'h00;
        run_chal(64'hDEAD_BEEF_0BAD_F00D, 0);
    endtask

    initial begin
        t_reset();
        t_boundary();
        t_scatter();
        t_fresh();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule